// File: doc/BRIEF.md
# Core Cycle Counter with Prescaler and Routed Overflow Interrupt

This block sits next to a processor core and counts the core's cycles in a 32-bit register. Each asserted `tick_i` is one elapsed core cycle. When counting is switched on, the register gains one on every tick. In divide mode it gains one for every 64 ticks instead. A 6-bit remainder accumulator holds the ticks that have not yet made up a full group of 64.

When the count steps past all-ones it wraps to zero and sets a sticky overflow flag. If the interrupt enable is on, the flag drives a level interrupt request. A routing bit sends that request either to the fast interrupt line or to the normal interrupt line. Software uses a single-cycle write port with a one-bit register select. Reads are combinational from the same select.

Top module: `cyc_counter_top`

## Requirements
- R1: While control bit 0 (run) is 1 and divide mode is off, each cycle with `tick_i`=1 raises the count (select 1) by exactly one. The new value is visible on the cycle after the tick.
- R2: While run is 0, ticks leave the count unchanged. Cycles without a tick also leave the count unchanged.
- R3: With control bit 1 (divide) set, the count steps once per 64 ticks. Starting from an empty accumulator, ticks 1 to 63 leave the count unchanged and tick 64 raises it by one.
- R4: Every cycle in which divide is 0 empties the accumulator. When divide is set again, a full 64 ticks are needed before the next step.
- R5: A step from 0xFFFFFFFF gives a count of 0 and sets the overflow flag at control bit 4.
- R6: The overflow flag stays set until a control write carries 1 in bit 4. A control write with 0 in bit 4 leaves the flag as it is. If an overflow occurs in the same cycle as a clearing write, the flag stays set.
- R7: An interrupt request is present only while the flag is set and the interrupt-enable bit (control bit 2) is 1.
- R8: Control bit 3 set sends the request to `fiq_o`; cleared, it goes to `irq_o`. The two outputs are never high together.
- R9: A write to the count (select 1) in a tick cycle loads the written value. That cycle's step is lost and it raises no overflow.
- R10: Select 0 reads back run, divide, interrupt enable, route and flag in bits 0 to 4, with all upper bits zero. Select 1 reads the count. After reset all of these read 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One elapsed core cycle to account |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control, 1 selects count |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Normal interrupt request (level) |
| fiq_o | output | 1 | Fast interrupt request (level) |

## Verification
Two pairs of events can fall in the same cycle here. A count write can land in the cycle where a tick would wrap the count, and a flag-clearing control write can land in the cycle where an overflow happens. Directed cases preload 0xFFFFFFFF and then issue the write together with a tick. The expected result is the written value with no flag in the first case, and a flag that stays set in the second. Random traffic biases count writes toward values near all-ones so that both collisions also occur unplanned, and every cycle is compared against a bench model.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int F_RUN   = 0;
  localparam int F_DIV   = 1;
  localparam int F_IE    = 2;
  localparam int F_ROUTE = 3;
  localparam int F_OVF   = 4;
  localparam int CTRL_W  = 5;

  typedef struct packed {
    logic ovf;
    logic route;
    logic ie;
    logic div;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/cyc_prescale.sv
module cyc_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic div_i,
  input  logic tick_i,
  output logic step_o
);
  localparam logic [DIV_LOG2-1:0] ACC_LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] acc_q;
  logic                live_tick;
  logic                acc_full;

  function automatic logic [DIV_LOG2-1:0] acc_next(input logic [DIV_LOG2-1:0] a);
    return a + {{(DIV_LOG2-1){1'b0}}, 1'b1};
  endfunction

  assign live_tick = run_i & tick_i;
  assign acc_full  = (acc_q == ACC_LAST);
  assign step_o    = live_tick & (div_i ? acc_full : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (!div_i)     acc_q <= '0;
    else if (live_tick)  acc_q <= acc_next(acc_q);
  end

  AST_ACC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !div_i |=> (acc_q == '0)); // R4
  AST_DIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i && live_tick && !acc_full) |-> !step_o); // R3
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i && !live_tick) |=> $stable(acc_q)); // R3
endmodule

// File: rtl/cyc_count.sv
module cyc_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  function automatic logic [CNT_W-1:0] cnt_inc(input logic [CNT_W-1:0] v);
    return v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign at_top = &cnt_q;
  assign ovf_o  = step_i & ~wr_i & at_top;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (step_i) cnt_q <= cnt_inc(cnt_q);
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !wr_i) |=> $stable(cnt_q)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == '0)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(wdata_i))); // R9
endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
  import cyc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              ovf_i,
  output ctrl_t             ctrl_o,
  output logic              irq_o,
  output logic              fiq_o
);
  ctrl_t ctrl_q;
  logic  clr_req;
  logic  req;

  assign clr_req = wr_i & wdata_i[F_OVF];
  assign req     = ctrl_q.ovf & ctrl_q.ie;
  assign irq_o   = req & ~ctrl_q.route;
  assign fiq_o   = req &  ctrl_q.route;
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i) begin
        ctrl_q.run   <= wdata_i[F_RUN];
        ctrl_q.div   <= wdata_i[F_DIV];
        ctrl_q.ie    <= wdata_i[F_IE];
        ctrl_q.route <= wdata_i[F_ROUTE];
      end
      if (ovf_i)        ctrl_q.ovf <= 1'b1;
      else if (clr_req) ctrl_q.ovf <= 1'b0;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> ctrl_q.ovf); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf && !clr_req) |=> ctrl_q.ovf); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !ovf_i) |=> !ctrl_q.ovf); // R6
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o)); // R8
endmodule

// File: rtl/cyc_counter_top.sv
module cyc_counter_top
  import cyc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int PAD_W = CNT_W - CTRL_W;

  ctrl_t            ctrl;
  logic             wr_ctrl;
  logic             wr_cnt;
  logic             step;
  logic             ovf_evt;
  logic [CNT_W-1:0] cnt;

  assign wr_ctrl = reg_wr_i & ~reg_sel_i;
  assign wr_cnt  = reg_wr_i &  reg_sel_i;

  cyc_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl.run), .div_i(ctrl.div),
    .tick_i(tick_i), .step_o(step));

  cyc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(step), .wr_i(wr_cnt),
    .wdata_i(reg_wdata_i), .cnt_o(cnt), .ovf_o(ovf_evt));

  cyc_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl),
    .wdata_i(reg_wdata_i[CTRL_W-1:0]), .ovf_i(ovf_evt),
    .ctrl_o(ctrl), .irq_o(irq_o), .fiq_o(fiq_o));

  assign reg_rdata_o = reg_sel_i ? cnt : {{PAD_W{1'b0}}, ctrl};

  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_cnt) |=> $stable(cnt)); // R2
  AST_REQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ctrl.ie && !wr_ctrl) |=> (irq_o || fiq_o)); // R7
  AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> (ctrl.ovf && ctrl.ie)); // R7
endmodule

// File: tb/sim_cyc_counter_top.sv
module sim_cyc_counter_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, fiq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic        m_run, m_div, m_ie, m_route, m_flag;
  logic [31:0] m_cnt;
  logic [5:0]  m_acc;

  always #4 clk = ~clk;

  cyc_counter_top u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .fiq_o(fiq_o));

  function automatic logic [31:0] ctrl_word();
    return {27'd0, m_flag, m_route, m_ie, m_div, m_run};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // model one clock edge from the values present before it
  task automatic model_edge(input logic tk, input logic wr, input logic sel, input logic [31:0] wd);
    logic stp, ovf, wc, wk;
    wc  = wr & sel;
    wk  = wr & ~sel;
    stp = m_run & tk & (m_div ? (m_acc == 6'd63) : 1'b1);
    ovf = stp & ~wc & (m_cnt == 32'hFFFF_FFFF);
    if (!m_div) m_acc = '0;
    else if (m_run & tk) m_acc = m_acc + 6'd1;
    if (wc) m_cnt = wd;
    else if (stp) m_cnt = m_cnt + 32'd1;
    if (ovf) m_flag = 1'b1;
    else if (wk & wd[4]) m_flag = 1'b0;
    if (wk) begin
      m_run = wd[0]; m_div = wd[1]; m_ie = wd[2]; m_route = wd[3];
    end
  endtask

  // inputs driven on the falling edge, results sampled 1 ns after the rising edge
  task automatic cyc(input logic tk, input logic wr, input logic sel, input logic [31:0] wd);
    tick_i = tk; reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
    @(posedge clk);
    model_edge(tk, wr, sel, wd);
    #1;
    if (sel) chk("R1 count", reg_rdata_o, m_cnt);
    else     chk("R10 control", reg_rdata_o, ctrl_word());
    chk("R7 irq", {31'd0, irq_o}, {31'd0, m_flag & m_ie & ~m_route});
    chk("R8 fiq", {31'd0, fiq_o}, {31'd0, m_flag & m_ie & m_route});
    @(negedge clk);
    tick_i = 1'b0; reg_wr_i = 1'b0;
  endtask

  task automatic peek(input logic sel);
    cyc(1'b0, 1'b0, sel, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_run = 0; m_div = 0; m_ie = 0; m_route = 0; m_flag = 0; m_cnt = '0; m_acc = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset control", reg_rdata_o, 32'd0);
    chk("R10 reset irq/fiq", {30'd0, irq_o, fiq_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    peek(1'b1);
    chk("R10 reset count", reg_rdata_o, 32'd0);

    // R1 plain counting
    cyc(1'b0, 1'b1, 1'b0, 32'h1);
    repeat (5) cyc(1'b1, 1'b0, 1'b1, 32'd0);
    chk("R1 five ticks", reg_rdata_o, 32'd5);
    cyc(1'b0, 1'b0, 1'b1, 32'd0);
    chk("R2 no tick holds", reg_rdata_o, 32'd5);

    // R2 stopped
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    repeat (7) cyc(1'b1, 1'b0, 1'b1, 32'd0);
    chk("R2 stopped", reg_rdata_o, 32'd5);

    // R3 divide by 64
    cyc(1'b0, 1'b1, 1'b0, 32'h3);
    cyc(1'b0, 1'b1, 1'b1, 32'd0);
    repeat (63) cyc(1'b1, 1'b0, 1'b1, 32'd0);
    chk("R3 63 ticks", reg_rdata_o, 32'd0);
    cyc(1'b1, 1'b0, 1'b1, 32'd0);
    chk("R3 64th tick", reg_rdata_o, 32'd1);

    // R4 leaving divide empties the accumulator
    repeat (10) cyc(1'b1, 1'b0, 1'b1, 32'd0);
    cyc(1'b0, 1'b1, 1'b0, 32'h1);
    cyc(1'b0, 1'b0, 1'b1, 32'd0);
    cyc(1'b0, 1'b1, 1'b0, 32'h3);
    repeat (63) cyc(1'b1, 1'b0, 1'b1, 32'd0);
    chk("R4 restart 63", reg_rdata_o, 32'd1);
    cyc(1'b1, 1'b0, 1'b1, 32'd0);
    chk("R4 restart 64", reg_rdata_o, 32'd2);

    // R5/R7 wrap, irq routing
    cyc(1'b0, 1'b1, 1'b0, 32'h5);
    cyc(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cyc(1'b1, 1'b0, 1'b1, 32'd0);
    chk("R5 wrap to zero", reg_rdata_o, 32'd0);
    peek(1'b0);
    chk("R5 flag set", reg_rdata_o, 32'h15);
    chk("R7 irq high", {31'd0, irq_o}, 32'd1);
    // R8 route to fast line, flag kept by writing 0 in bit 4
    cyc(1'b0, 1'b1, 1'b0, 32'hD);
    chk("R8 fiq high", {30'd0, irq_o, fiq_o}, 32'd1);
    chk("R6 zero keeps flag", reg_rdata_o, 32'h1D);
    cyc(1'b0, 1'b1, 1'b0, 32'h9);
    chk("R7 ie off no req", {30'd0, irq_o, fiq_o}, 32'd0);
    // R6 clear by writing 1
    cyc(1'b0, 1'b1, 1'b0, 32'h15);
    chk("R6 w1c", reg_rdata_o, 32'h5);
    chk("R7 cleared no req", {30'd0, irq_o, fiq_o}, 32'd0);
    // R6 overflow beats clear
    cyc(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cyc(1'b1, 1'b1, 1'b0, 32'h15);
    chk("R6 set beats clear", reg_rdata_o, 32'h15);
    cyc(1'b0, 1'b1, 1'b0, 32'h15);
    // R9 count write beats step and overflow
    cyc(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cyc(1'b1, 1'b1, 1'b1, 32'h7);
    chk("R9 write wins", reg_rdata_o, 32'h7);
    peek(1'b0);
    chk("R9 no overflow", reg_rdata_o, 32'h5);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, wd;
      logic tk, wr, sel;
      r   = $urandom;
      tk  = (r[3:0] != 4'd0);
      wr  = (r[8:4] == 5'd0);
      sel = r[9];
      if (sel) wd = r[11:10] == 2'd0 ? $urandom : 32'hFFFF_FFFF - {28'd0, r[15:12]};
      else     wd = {27'd0, r[20] & r[21], r[19:18], r[17] & r[16] & r[22], 1'b1};
      cyc(tk, wr, sel, wd);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule